// File: doc/BRIEF.md
# Interprocessor Packet Interface Unit

This unit connects a processor to its node's port on the mesh network. The processor builds outgoing packets word by word into a transmit queue, and the unit launches each one onto the network only after every word of it is in place. Arriving packets are sorted by their opcode. An opcode whose most significant bit is set marks an interprocessor interrupt message, and that packet is stored whole in a software input queue. Any other opcode marks a coherence protocol packet, which is passed on a stream to the coherence controller.

A packet is a header word, then an opcode word, then zero to fifteen operand words, then zero to fifteen data words. Header bits [15:8] carry the sending node's identifier. Bits [7:4] carry the operand count and bits [3:0] the data-word count. The unit reads these two counts to find where each packet ends, and flags its final word on every stream. While the software queue holds at least one complete packet, a trap line to the processor stays high. The processor drains the queue one word at a time.

Top module: `ipi_unit`

## Requirements
- R1: A packet occupies 2 + ops + data words, where ops is header bits [7:4] and data is header bits [3:0]; words are carried in order without alteration.
- R2: When the transmit unit is between packets, it accepts a header word (tx_ready high) only if the transmit queue has free space for the whole packet that header describes; once a header is accepted, all remaining words of that packet are accepted.
- R3: No word of a transmit packet appears on net_tx_valid before the packet's final word has been written; net_tx_last is high exactly on each packet's final word.
- R4: While net_tx_valid is high and net_tx_ready is low, net_tx_valid, net_tx_data and net_tx_last hold their values.
- R5: A received packet whose opcode word has bit 31 (the most significant bit) set is written whole, header included, into the software queue; a packet with that bit clear is passed whole to the protocol stream and nothing of it enters the software queue.
- R6: sw_rd_last and proto_last are high exactly on the final word of each packet.
- R7: A received interrupt packet is held back (net_rx_ready low after its header) until the software queue has free space for all of its words.
- R8: sw_trap is high while the software queue holds at least one complete packet; a partly received packet does not raise it, and it falls once software has popped the final word of the last stored packet.
- R9: While proto_valid is high and proto_ready is low, proto_valid and proto_data hold, and net_rx_ready stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Processor offers a transmit word |
| tx_data | input | W | Transmit word (header first) |
| tx_ready | output | 1 | Transmit word accepted this cycle |
| net_tx_valid | output | 1 | Word available for the network |
| net_tx_data | output | W | Word to the network |
| net_tx_last | output | 1 | Final word of the outgoing packet |
| net_tx_ready | input | 1 | Network takes the word |
| net_rx_valid | input | 1 | Network offers a received word |
| net_rx_data | input | W | Received word (header first) |
| net_rx_ready | output | 1 | Received word taken this cycle |
| proto_valid | output | 1 | Protocol packet word available |
| proto_data | output | W | Protocol packet word |
| proto_last | output | 1 | Final word of the protocol packet |
| proto_ready | input | 1 | Coherence controller takes the word |
| sw_rd_valid | output | 1 | Software queue has a readable word |
| sw_rd_data | output | W | Word at the head of the software queue |
| sw_rd_last | output | 1 | Head word is the final word of its packet |
| sw_rd_pop | input | 1 | Software removes the head word |
| sw_trap | output | 1 | Trap request: a complete packet is waiting |

## Verification
The bench builds the unit with 32-bit words and both queues 32 words deep, which is exactly the largest packet. With that depth, a stalled 20-word packet leaves too little room for a following 14-word packet in either direction. The header refusal on the transmit side and the hold on the receive side can therefore be reached with short runs. The same small depth lets the bench stall a packet half-written and watch that neither the network output nor the trap line reacts.

// File: rtl/ipi_pkg.sv
`timescale 1ns/1ps
package ipi_pkg;

  // Header fields: [7:4] operand count, [3:0] data-word count, [15:8] source node.
  localparam int CNT_W   = 4;
  localparam int WORDS_W = 6;   // up to 2 + 15 + 15 = 32 words

  typedef enum logic [1:0] {
    RX_HDR   = 2'd0,
    RX_ROUTE = 2'd1,
    RX_BODY  = 2'd2
  } rx_state_e;

  typedef enum logic {
    DST_PROTO = 1'b0,
    DST_SW    = 1'b1
  } rx_dest_e;

  // Total words of a packet from the low byte of its header.
  function automatic logic [WORDS_W-1:0] pkt_words(input logic [7:0] len_f);
    return WORDS_W'(2) + WORDS_W'(len_f[7:4]) + WORDS_W'(len_f[3:0]);
  endfunction

  // Interrupt messages carry a set top bit in the opcode word.
  function automatic rx_dest_e classify(input logic op_msb);
    return op_msb ? DST_SW : DST_PROTO;
  endfunction

endpackage

// File: rtl/ipi_pkt_fifo.sv
`timescale 1ns/1ps
module ipi_pkt_fifo #(
  parameter  int W     = 32,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          wr_last,
  output logic [PW-1:0] free,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          rd_last,
  input  logic          rd_pop,
  output logic [PW-1:0] pkt_cnt
);

  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [W:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic          commit_ev, retire_ev, pop_ev;

  assign free      = DEPTH_P - (wr_ptr - rd_ptr);
  assign rd_valid  = (rd_ptr != cm_ptr);
  assign pop_ev    = rd_pop & rd_valid;
  assign commit_ev = wr_en & wr_last;
  assign retire_ev = pop_ev & rd_last;
  assign {rd_last, rd_data} = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= {wr_last, wr_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      cm_ptr  <= '0;
      rd_ptr  <= '0;
      pkt_cnt <= '0;
    end else begin
      if (wr_en)     wr_ptr <= wr_ptr + PW'(1);
      if (commit_ev) cm_ptr <= wr_ptr + PW'(1);
      if (pop_ev)    rd_ptr <= rd_ptr + PW'(1);
      case ({commit_ev, retire_ev})
        2'b10:   pkt_cnt <= pkt_cnt + PW'(1);
        2'b01:   pkt_cnt <= pkt_cnt - PW'(1);
        default: pkt_cnt <= pkt_cnt;
      endcase
    end
  end

  // R2 / R7: a writer never pushes into a full queue.
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> free != '0);

  // R3 / R8: words of an unfinished packet are never readable.
  a_r8_no_partial_read: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_cnt == '0 |-> !rd_valid);

endmodule

// File: rtl/ipi_tx_framer.sv
`timescale 1ns/1ps
module ipi_tx_framer #(
  parameter  int W     = 32,
  parameter  int DEPTH = 64,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_valid,
  input  logic [W-1:0]  tx_data,
  output logic          tx_ready,
  input  logic [PW-1:0] free,
  output logic          wr_en,
  output logic [W-1:0]  wr_data,
  output logic          wr_last
);
  import ipi_pkg::*;

  logic               in_body;
  logic [WORDS_W-1:0] remain;
  logic [WORDS_W-1:0] words;
  logic               room_ok;
  logic               hdr_fire;
  logic               body_fire;

  assign words     = pkt_words(tx_data[7:0]);
  assign room_ok   = int'(free) >= int'(words);
  assign tx_ready  = in_body ? 1'b1 : room_ok;
  assign wr_en     = tx_valid & tx_ready;
  assign wr_data   = tx_data;
  assign wr_last   = in_body && (remain == WORDS_W'(1));
  assign hdr_fire  = wr_en & ~in_body;
  assign body_fire = wr_en & in_body;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_body <= 1'b0;
      remain  <= '0;
    end else if (hdr_fire) begin
      in_body <= 1'b1;
      remain  <= words - WORDS_W'(1);
    end else if (body_fire) begin
      remain <= remain - WORDS_W'(1);
      if (remain == WORDS_W'(1)) in_body <= 1'b0;
    end
  end

  // R2: space claimed at the header is still there for every body word.
  a_r2_body_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    in_body |-> free != '0);

  // R1: a packet body always has at least one word after the header.
  a_r1_header_opens_body: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> in_body && remain != '0);

endmodule

// File: rtl/ipi_rx_classifier.sv
`timescale 1ns/1ps
module ipi_rx_classifier #(
  parameter  int W     = 32,
  parameter  int DEPTH = 64,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          net_rx_valid,
  input  logic [W-1:0]  net_rx_data,
  output logic          net_rx_ready,
  input  logic [PW-1:0] sw_free,
  output logic          sw_wr_en,
  output logic [W-1:0]  sw_wr_data,
  output logic          sw_wr_last,
  output logic          proto_valid,
  output logic [W-1:0]  proto_data,
  output logic          proto_last,
  input  logic          proto_ready
);
  import ipi_pkg::*;

  rx_state_e          state;
  rx_dest_e           dest, want;
  logic [W-1:0]       hdr_q;
  logic [WORDS_W-1:0] remain;
  logic [WORDS_W-1:0] words_q;
  logic               room_ok;
  logic               route_fire;
  logic               body_fire;
  logic               body_end;

  assign words_q  = pkt_words(hdr_q[7:0]);
  assign room_ok  = int'(sw_free) >= int'(words_q);
  assign want     = classify(net_rx_data[W-1]);
  assign body_end = (remain == WORDS_W'(1));

  always_comb begin
    net_rx_ready = 1'b0;
    sw_wr_en     = 1'b0;
    sw_wr_data   = net_rx_data;
    sw_wr_last   = 1'b0;
    proto_valid  = 1'b0;
    proto_data   = net_rx_data;
    proto_last   = 1'b0;
    route_fire   = 1'b0;
    case (state)
      RX_HDR: net_rx_ready = 1'b1;
      RX_ROUTE: begin
        sw_wr_data = hdr_q;
        proto_data = hdr_q;
        if (net_rx_valid) begin
          if (want == DST_SW) begin
            sw_wr_en   = room_ok;
            route_fire = room_ok;
          end else begin
            proto_valid = 1'b1;
            route_fire  = proto_ready;
          end
        end
      end
      RX_BODY: begin
        sw_wr_last = body_end;
        proto_last = body_end;
        if (dest == DST_SW) begin
          net_rx_ready = 1'b1;
          sw_wr_en     = net_rx_valid;
        end else begin
          net_rx_ready = proto_ready;
          proto_valid  = net_rx_valid;
        end
      end
      default: net_rx_ready = 1'b0;
    endcase
  end

  assign body_fire = (state == RX_BODY) && net_rx_valid && net_rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RX_HDR;
      dest   <= DST_PROTO;
      hdr_q  <= '0;
      remain <= '0;
    end else begin
      case (state)
        RX_HDR: if (net_rx_valid) begin
          hdr_q  <= net_rx_data;
          remain <= pkt_words(net_rx_data[7:0]) - WORDS_W'(1);
          state  <= RX_ROUTE;
        end
        RX_ROUTE: if (route_fire) begin
          dest  <= want;
          state <= RX_BODY;
        end
        RX_BODY: if (body_fire) begin
          remain <= remain - WORDS_W'(1);
          if (body_end) state <= RX_HDR;
        end
        default: state <= RX_HDR;
      endcase
    end
  end

  // R9: a stalled protocol word is held steady.
  a_r9_proto_hold: assert property (@(posedge clk) disable iff (!rst_n)
    proto_valid && !proto_ready && state == RX_ROUTE |=> proto_valid && $stable(proto_data));

  // R5: a packet routed to software never leaks onto the protocol stream.
  a_r5_sw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    state == RX_BODY && dest == DST_SW |-> !proto_valid);

  // R7: room reserved when the header was stored covers every body word.
  a_r7_room_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    state == RX_BODY && dest == DST_SW && sw_wr_en |-> sw_free != '0);

endmodule

// File: rtl/ipi_unit.sv
`timescale 1ns/1ps
module ipi_unit #(
  parameter  int W        = 32,
  parameter  int TX_DEPTH = 64,
  parameter  int RX_DEPTH = 64,
  localparam int TPW      = $clog2(TX_DEPTH) + 1,
  localparam int RPW      = $clog2(RX_DEPTH) + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ready,
  output logic         net_tx_valid,
  output logic [W-1:0] net_tx_data,
  output logic         net_tx_last,
  input  logic         net_tx_ready,
  input  logic         net_rx_valid,
  input  logic [W-1:0] net_rx_data,
  output logic         net_rx_ready,
  output logic         proto_valid,
  output logic [W-1:0] proto_data,
  output logic         proto_last,
  input  logic         proto_ready,
  output logic         sw_rd_valid,
  output logic [W-1:0] sw_rd_data,
  output logic         sw_rd_last,
  input  logic         sw_rd_pop,
  output logic         sw_trap
);

  logic           tq_wr_en, tq_wr_last;
  logic [W-1:0]   tq_wr_data;
  logic [TPW-1:0] tq_free, tq_pkts;
  logic           sq_wr_en, sq_wr_last;
  logic [W-1:0]   sq_wr_data;
  logic [RPW-1:0] sq_free, sq_pkts;

  ipi_tx_framer #(.W(W), .DEPTH(TX_DEPTH)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .free(tq_free),
    .wr_en(tq_wr_en), .wr_data(tq_wr_data), .wr_last(tq_wr_last)
  );

  ipi_pkt_fifo #(.W(W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tq_wr_en), .wr_data(tq_wr_data), .wr_last(tq_wr_last),
    .free(tq_free),
    .rd_valid(net_tx_valid), .rd_data(net_tx_data), .rd_last(net_tx_last),
    .rd_pop(net_tx_ready), .pkt_cnt(tq_pkts)
  );

  ipi_rx_classifier #(.W(W), .DEPTH(RX_DEPTH)) u_rxc (
    .clk(clk), .rst_n(rst_n),
    .net_rx_valid(net_rx_valid), .net_rx_data(net_rx_data), .net_rx_ready(net_rx_ready),
    .sw_free(sq_free),
    .sw_wr_en(sq_wr_en), .sw_wr_data(sq_wr_data), .sw_wr_last(sq_wr_last),
    .proto_valid(proto_valid), .proto_data(proto_data), .proto_last(proto_last),
    .proto_ready(proto_ready)
  );

  ipi_pkt_fifo #(.W(W), .DEPTH(RX_DEPTH)) u_swq (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sq_wr_en), .wr_data(sq_wr_data), .wr_last(sq_wr_last),
    .free(sq_free),
    .rd_valid(sw_rd_valid), .rd_data(sw_rd_data), .rd_last(sw_rd_last),
    .rd_pop(sw_rd_pop), .pkt_cnt(sq_pkts)
  );

  assign sw_trap = (sq_pkts != '0);

  // R4: the network side sees a stable word while it stalls.
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid && !net_tx_ready |=> net_tx_valid && $stable(net_tx_data) && $stable(net_tx_last));

  // R3: output only flows once a whole packet sits in the transmit queue.
  a_r3_launch_whole: assert property (@(posedge clk) disable iff (!rst_n)
    net_tx_valid |-> tq_pkts != '0);

  // R8: the trap drops only as the final word of a packet leaves.
  a_r8_trap_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_trap) |-> $past(sw_rd_pop && sw_rd_valid && sw_rd_last));

endmodule

// File: tb/ipi_unit_tb.sv
`timescale 1ns/1ps
module ipi_unit_tb;
  localparam int W  = 32;
  localparam int TD = 32;
  localparam int RD = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic tx_valid, tx_ready;
  logic [W-1:0] tx_data;
  logic net_tx_valid, net_tx_last, net_tx_ready;
  logic [W-1:0] net_tx_data;
  logic net_rx_valid, net_rx_ready;
  logic [W-1:0] net_rx_data;
  logic proto_valid, proto_last, proto_ready;
  logic [W-1:0] proto_data;
  logic sw_rd_valid, sw_rd_last, sw_rd_pop, sw_trap;
  logic [W-1:0] sw_rd_data;

  ipi_unit #(.W(W), .TX_DEPTH(TD), .RX_DEPTH(RD)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .net_tx_valid(net_tx_valid), .net_tx_data(net_tx_data), .net_tx_last(net_tx_last),
    .net_tx_ready(net_tx_ready),
    .net_rx_valid(net_rx_valid), .net_rx_data(net_rx_data), .net_rx_ready(net_rx_ready),
    .proto_valid(proto_valid), .proto_data(proto_data), .proto_last(proto_last),
    .proto_ready(proto_ready),
    .sw_rd_valid(sw_rd_valid), .sw_rd_data(sw_rd_data), .sw_rd_last(sw_rd_last),
    .sw_rd_pop(sw_rd_pop), .sw_trap(sw_trap)
  );

  typedef struct packed { logic [W-1:0] d; logic l; } item_t;
  item_t exp_net[$], exp_sw[$], exp_pr[$];
  logic [W-1:0] pkt[$];
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Packet builder: header, opcode, operands, data (R1 layout).
  task automatic build(input bit irq, input logic [3:0] nops, input logic [3:0] nd,
                       input logic [7:0] src, input logic [7:0] seed);
    pkt.delete();
    pkt.push_back({16'h0, src, nops, nd});
    pkt.push_back({irq, 23'h0, seed});
    for (int i = 0; i < int'(nops) + int'(nd); i++)
      pkt.push_back({seed, 8'(i), 16'hA5C3 ^ 16'(i * 7)});
  endtask

  task automatic expect_on(input int which);
    for (int i = 0; i < pkt.size(); i++) begin
      item_t it;
      it.d = pkt[i];
      it.l = (i == pkt.size() - 1);
      if (which == 0) exp_net.push_back(it);
      else if (which == 1) exp_sw.push_back(it);
      else exp_pr.push_back(it);
    end
  endtask

  task automatic push_tx(input logic [W-1:0] w);
    @(negedge clk); tx_valid = 1'b1; tx_data = w; #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic push_rx(input logic [W-1:0] w);
    @(negedge clk); net_rx_valid = 1'b1; net_rx_data = w; #1;
    while (!net_rx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic send_tx(input int from, input int upto);
    for (int i = from; i < upto; i++) push_tx(pkt[i]);
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic send_rx(input int from, input int upto);
    for (int i = from; i < upto; i++) push_rx(pkt[i]);
    @(negedge clk); net_rx_valid = 1'b0;
  endtask

  task automatic pop_sw(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sw_rd_pop = 1'b1; #1;
      while (!sw_rd_valid) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk); sw_rd_pop = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // Scoreboard monitors, sampled 1 ns before each rising edge.
  initial forever begin
    item_t it;
    @(negedge clk); #1;
    if (rst_n && net_tx_valid && net_tx_ready) begin
      if (exp_net.size() == 0) check(0, "R3", "unexpected network word", net_tx_data, '0);
      else begin
        it = exp_net.pop_front();
        check(net_tx_data == it.d, "R1", "network data", net_tx_data, it.d);
        check(net_tx_last == it.l, "R3", "network last", W'(net_tx_last), W'(it.l));
      end
    end
    if (rst_n && proto_valid && proto_ready) begin
      if (exp_pr.size() == 0) check(0, "R5", "unexpected protocol word", proto_data, '0);
      else begin
        it = exp_pr.pop_front();
        check(proto_data == it.d, "R5", "protocol data", proto_data, it.d);
        check(proto_last == it.l, "R6", "protocol last", W'(proto_last), W'(it.l));
      end
    end
    if (rst_n && sw_rd_valid && sw_rd_pop) begin
      if (exp_sw.size() == 0) check(0, "R5", "unexpected software word", sw_rd_data, '0);
      else begin
        it = exp_sw.pop_front();
        check(sw_rd_data == it.d, "R5", "software data", sw_rd_data, it.d);
        check(sw_rd_last == it.l, "R6", "software last", W'(sw_rd_last), W'(it.l));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    bit rx_done;
    rst_n = 1'b0; tx_valid = 1'b0; tx_data = '0; net_tx_ready = 1'b0;
    net_rx_valid = 1'b0; net_rx_data = '0; proto_ready = 1'b0; sw_rd_pop = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // Reset state
    check(net_tx_valid == 1'b0, "R3", "reset net_tx_valid", W'(net_tx_valid), '0);
    check(proto_valid == 1'b0, "R5", "reset proto_valid", W'(proto_valid), '0);
    check(sw_rd_valid == 1'b0, "R5", "reset sw_rd_valid", W'(sw_rd_valid), '0);
    check(sw_trap == 1'b0, "R8", "reset sw_trap", W'(sw_trap), '0);
    check(tx_ready == 1'b1, "R2", "reset tx_ready", W'(tx_ready), 1);
    check(net_rx_ready == 1'b1, "R7", "reset net_rx_ready", W'(net_rx_ready), 1);

    // R1/R3: plain transmit of a 7-word packet
    net_tx_ready = 1'b1;
    build(0, 4'd2, 4'd3, 8'h11, 8'h01); expect_on(0);
    send_tx(0, pkt.size());
    idle(12);
    check(exp_net.size() == 0, "R1", "7-word packet drained", W'(exp_net.size()), '0);

    // R3: half-written packet is not launched
    build(1, 4'd1, 4'd1, 8'h12, 8'h02); expect_on(0);
    send_tx(0, 3);
    idle(5);
    check(net_tx_valid == 1'b0, "R3", "partial packet held back", W'(net_tx_valid), '0);
    send_tx(3, 4);
    idle(8);
    check(exp_net.size() == 0, "R3", "completed packet drained", W'(exp_net.size()), '0);

    // R2/R4: a full transmit queue refuses a header that does not fit
    net_tx_ready = 1'b0;
    build(0, 4'd9, 4'd9, 8'h13, 8'h03); expect_on(0);
    send_tx(0, pkt.size());
    build(1, 4'd6, 4'd6, 8'h14, 8'h04); expect_on(0);
    @(negedge clk); tx_valid = 1'b1; tx_data = pkt[0]; #1;
    check(tx_ready == 1'b0, "R2", "14-word header refused with 12 free", W'(tx_ready), '0);
    check(net_tx_valid == 1'b1, "R3", "complete packet offered", W'(net_tx_valid), 1);
    held = net_tx_data;
    idle(3);
    check(net_tx_valid == 1'b1 && net_tx_data == held, "R4", "stalled word holds", net_tx_data, held);
    check(tx_ready == 1'b0, "R2", "header still refused", W'(tx_ready), '0);
    net_tx_ready = 1'b1;
    send_tx(0, pkt.size());
    idle(40);
    check(exp_net.size() == 0, "R2", "both packets drained", W'(exp_net.size()), '0);

    // R8: partly received interrupt packet raises no trap
    build(1, 4'd3, 4'd0, 8'h21, 8'h05); expect_on(1);
    send_rx(0, 3);
    idle(3);
    check(sw_trap == 1'b0, "R8", "trap low on partial packet", W'(sw_trap), '0);
    send_rx(3, pkt.size());
    idle(2);
    check(sw_trap == 1'b1, "R8", "trap high on complete packet", W'(sw_trap), 1);
    pop_sw(5);
    idle(1);
    check(sw_trap == 1'b0, "R8", "trap low after pop", W'(sw_trap), '0);

    // R5/R8: two interrupt packets queued, trap holds until the last is gone
    build(1, 4'd1, 4'd2, 8'h22, 8'h06); expect_on(1);
    send_rx(0, pkt.size());
    build(1, 4'd0, 4'd0, 8'h23, 8'h07); expect_on(1);
    send_rx(0, pkt.size());
    idle(2);
    check(sw_rd_valid == 1'b1, "R5", "interrupt packet stored", W'(sw_rd_valid), 1);
    pop_sw(5);
    idle(1);
    check(sw_trap == 1'b1, "R8", "trap stays with one packet left", W'(sw_trap), 1);
    pop_sw(2);
    idle(1);
    check(sw_trap == 1'b0, "R8", "trap drops after final word", W'(sw_trap), '0);
    check(exp_sw.size() == 0, "R6", "software queue fully checked", W'(exp_sw.size()), '0);

    // R5/R6: protocol packet goes to the protocol stream only
    proto_ready = 1'b1;
    build(0, 4'd2, 4'd2, 8'h31, 8'h08); expect_on(2);
    send_rx(0, pkt.size());
    idle(3);
    check(exp_pr.size() == 0, "R5", "protocol packet delivered", W'(exp_pr.size()), '0);
    check(sw_rd_valid == 1'b0, "R5", "protocol packet not in software queue", W'(sw_rd_valid), '0);

    // R9: protocol backpressure stalls the receive side
    proto_ready = 1'b0;
    build(0, 4'd1, 4'd1, 8'h32, 8'h09); expect_on(2);
    rx_done = 0;
    fork begin send_rx(0, pkt.size()); rx_done = 1; end join_none
    idle(4);
    check(net_rx_ready == 1'b0, "R9", "network held while stalled", W'(net_rx_ready), '0);
    check(proto_valid == 1'b1 && proto_data == pkt[0], "R9", "stalled header offered", proto_data, pkt[0]);
    idle(2);
    check(proto_data == pkt[0], "R9", "stalled header holds", proto_data, pkt[0]);
    proto_ready = 1'b1;
    wait (rx_done);
    idle(3);
    check(exp_pr.size() == 0, "R9", "stalled packet delivered", W'(exp_pr.size()), '0);

    // R7: interrupt packet waits for room in the software queue
    build(1, 4'd9, 4'd9, 8'h41, 8'h0A); expect_on(1);
    send_rx(0, pkt.size());
    build(1, 4'd6, 4'd6, 8'h42, 8'h0B); expect_on(1);
    rx_done = 0;
    fork begin send_rx(0, pkt.size()); rx_done = 1; end join_none
    idle(5);
    check(net_rx_ready == 1'b0, "R7", "receive held for room", W'(net_rx_ready), '0);
    check(sw_trap == 1'b1, "R8", "trap with first packet stored", W'(sw_trap), 1);
    pop_sw(34);
    wait (rx_done);
    idle(2);
    check(exp_sw.size() == 0, "R7", "both packets read whole", W'(exp_sw.size()), '0);
    check(sw_trap == 1'b0, "R8", "trap low after draining", W'(sw_trap), '0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule